// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Tracker

This block follows one 8-thread warp through conditional branches and decides which threads are enabled and which PC comes next. A branch is a predicated instruction: every thread has its own predicate bit, and that bit decides whether the thread takes the branch. When all enabled threads agree, the warp follows that direction and the stack does not change.

When the enabled threads disagree, the warp splits. The taken side runs first with only its threads enabled. The block pushes two entries onto an internal stack. One is a pending entry holding the fall-through PC and the not-taken threads. The other is a rejoin entry holding the reconvergence PC and the mask that was active before the split. Each entry also records the reconvergence PC that triggers its pop.

When a step's next PC equals the reconvergence PC of the top entry, the entry is popped. Popping the pending entry resumes the not-taken side. Popping the rejoin entry restores the full earlier mask at the reconvergence point. The fetch pipeline supplies one step per instruction, with the fall-through PC and, on branches, the predicate vector, target and reconvergence PC.

Top module: `simt_reconv_stack`

## Requirements
- R1: After a synchronous reset, `pc_out` equals the `RESET_PC` parameter (default 0), `mask_out` is all ones and `overflow` is 0.
- R2: In a cycle with `step_valid` low, `pc_out` and `mask_out` keep their values.
- R3: A step with `br_valid` low sets `pc_out` to `fall_pc` and leaves `mask_out` unchanged, provided no stack entry is hit.
- R4: A branch on which every enabled thread agrees pushes nothing and leaves the mask unchanged. If all of them take it, `pc_out` becomes `target_pc`; if none take it, `pc_out` becomes `fall_pc`.
- R5: Thread i's effective predicate is `br_pred[i]` XOR `br_negate`. A 1 means the thread takes the branch.
- R6: A divergent branch sets `pc_out` to `target_pc` and `mask_out` to the old mask AND the effective predicate.
- R7: When the taken side steps to the reconvergence PC, `pc_out` becomes that branch's `fall_pc`. `mask_out` becomes the pre-split mask AND NOT the effective predicate.
- R8: When the not-taken side steps to the reconvergence PC, `pc_out` becomes that PC and `mask_out` becomes the pre-split mask. Whenever the stack is empty, the mask is all ones.
- R9: Outside a pop, no step ever turns on a thread that was disabled. Predicate bits of disabled threads have no effect.
- R10: If a divergent branch's `fall_pc` equals its reconvergence PC, the taken side reaching that PC goes straight there with the pre-split mask.
- R11: If a divergent branch's `target_pc` equals its reconvergence PC, only a rejoin entry is pushed. The not-taken side starts at once: `pc_out` becomes `fall_pc` with the not-taken mask.
- R12: When a nested region's rejoin entry is popped and its PC equals the next entry's reconvergence PC, both entries pop in one step and the outer pending side resumes.
- R13: A divergent branch that needs more entries than are free sets `overflow`, which stays set until reset. In that case `pc_out` and `mask_out` do not change.
- R14: A stack of `DEPTH` entries (default 8) holds `DEPTH/2` nested two-entry divergences without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | One instruction step is presented this cycle |
| br_valid | input | 1 | The step is a conditional branch |
| br_pred | input | 8 | Per-thread branch predicate, bit i for thread i |
| br_negate | input | 1 | Invert the predicate before use |
| target_pc | input | 16 | Branch target PC |
| fall_pc | input | 16 | Fall-through (sequential) PC |
| reconv_pc | input | 16 | Reconvergence PC of the branch |
| pc_out | output | 16 | Next PC to fetch |
| mask_out | output | 8 | Active thread mask |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
Every result of this block appears one clock edge after the edge that accepts a step: the new PC, the new mask, the overflow flag and each pop. The bench drives a step's inputs on a falling edge and samples the outputs on the next falling edge. By that point exactly one rising edge has registered the step. Each step therefore gets its expected PC and mask checked before the next step is applied. Nested and shared reconvergence points are walked one step at a time, so every push and pop is seen at its own cycle.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int WARP_W = 8;
    localparam int PC_W   = 16;

    typedef logic [WARP_W-1:0] tmask_t;
    typedef logic [PC_W-1:0]   pc_t;

    // One stack record: pop trigger, resume PC and resume mask
    typedef struct packed {
        pc_t    rpc;
        pc_t    pc;
        tmask_t mask;
    } stk_ent_t;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_ALL_TAKEN,
        BR_NONE_TAKEN,
        BR_SPLIT
    } br_kind_e;

    function automatic tmask_t eff_pred(tmask_t p, logic neg);
        return neg ? ~p : p;
    endfunction

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
    import simt_pkg::*;
(
    input  logic     br_valid,
    input  tmask_t   pred,
    input  logic     negate,
    input  tmask_t   cur_mask,
    output br_kind_e kind,
    output tmask_t   taken_mask,
    output tmask_t   skip_mask
);

    tmask_t eff;

    always_comb begin
        eff        = eff_pred(pred, negate);
        taken_mask = eff & cur_mask;
        skip_mask  = ~eff & cur_mask;
        if (!br_valid)
            kind = BR_NONE;
        else if (taken_mask == '0)
            kind = BR_NONE_TAKEN;
        else if (skip_mask == '0)
            kind = BR_ALL_TAKEN;
        else
            kind = BR_SPLIT;
    end

endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store
    import simt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  stk_ent_t      push_lo,
    input  stk_ent_t      push_hi,
    input  logic [1:0]    pop_n,
    output stk_ent_t      top_ent,
    output stk_ent_t      next_ent,
    output logic [CW-1:0] count
);

    stk_ent_t slot [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_n != 2'd0 && count == CW'(i))
                slot[i] <= push_lo;
            else if (push_n == 2'd2 && count + CW'(1) == CW'(i))
                slot[i] <= push_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count + CW'(push_n) - CW'(pop_n);
    end

    always_comb begin
        top_ent  = '0;
        next_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count == CW'(i + 1)) top_ent  = slot[i];
            if (count == CW'(i + 2)) next_ent = slot[i];
        end
    end

    // R14
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R13
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(pop_n) <= int'(count));

    // R13
    no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) + int'(push_n) <= DEPTH);

    // R14
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push_n != 2'd0) |=> int'(count) == int'($past(count)) + int'($past(push_n)));

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int  DEPTH    = 8,
    parameter pc_t RESET_PC = '0,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step_valid,
    input  logic                         br_valid,
    input  logic [simt_pkg::WARP_W-1:0]  br_pred,
    input  logic                         br_negate,
    input  logic [simt_pkg::PC_W-1:0]    target_pc,
    input  logic [simt_pkg::PC_W-1:0]    fall_pc,
    input  logic [simt_pkg::PC_W-1:0]    reconv_pc,
    output logic [simt_pkg::PC_W-1:0]    pc_out,
    output logic [simt_pkg::WARP_W-1:0]  mask_out,
    output logic                         overflow
);

    pc_t      pc_q, pc_d;
    tmask_t   mask_q, mask_d;
    logic     ovf_q, ovf_d;
    br_kind_e kind;
    tmask_t   taken_m, skip_m;
    stk_ent_t top_e, next_e, lo_e, hi_e;
    logic [CW-1:0] count;
    logic [1:0] push_n, pop_n, need;
    pc_t      cand;
    logic     hit, room;

    simt_branch_eval u_eval (
        .br_valid   (br_valid),
        .pred       (br_pred),
        .negate     (br_negate),
        .cur_mask   (mask_q),
        .kind       (kind),
        .taken_mask (taken_m),
        .skip_mask  (skip_m)
    );

    simt_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_n   (push_n),
        .push_lo  (lo_e),
        .push_hi  (hi_e),
        .pop_n    (pop_n),
        .top_ent  (top_e),
        .next_ent (next_e),
        .count    (count)
    );

    always_comb begin
        need = (target_pc == reconv_pc) ? 2'd1 : 2'd2;
        room = (int'(count) + int'(need)) <= DEPTH;
        cand = (kind == BR_ALL_TAKEN) ? target_pc : fall_pc;
        hit  = (count != '0) && (cand == top_e.rpc);
    end

    always_comb begin
        pc_d   = pc_q;
        mask_d = mask_q;
        ovf_d  = ovf_q;
        push_n = 2'd0;
        pop_n  = 2'd0;
        lo_e   = '{rpc: reconv_pc, pc: reconv_pc, mask: mask_q};
        hi_e   = '{rpc: reconv_pc, pc: fall_pc,   mask: skip_m};
        if (step_valid) begin
            if (kind == BR_SPLIT) begin
                if (!room) begin
                    ovf_d = 1'b1;
                end else if (need == 2'd1) begin
                    push_n = 2'd1;
                    pc_d   = fall_pc;
                    mask_d = skip_m;
                end else begin
                    push_n = 2'd2;
                    pc_d   = target_pc;
                    mask_d = taken_m;
                end
            end else if (hit) begin
                if (count >= CW'(2) && top_e.pc == next_e.rpc) begin
                    pop_n  = 2'd2;
                    pc_d   = next_e.pc;
                    mask_d = next_e.mask;
                end else begin
                    pop_n  = 2'd1;
                    pc_d   = top_e.pc;
                    mask_d = top_e.mask;
                end
            end else begin
                pc_d = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            ovf_q  <= ovf_d;
        end
    end

    assign pc_out   = pc_q;
    assign mask_out = mask_q;
    assign overflow = ovf_q;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> $stable(pc_out) && $stable(mask_out));

    // R9
    no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && pop_n == 2'd0) |=> (mask_out & ~$past(mask_out)) == '0);

    // R13
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R13
    ovf_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && kind == BR_SPLIT && !room) |=> $stable(pc_out) && $stable(mask_out));

    // R8
    empty_full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> mask_out == '1);

    // R6
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        mask_out != '0);

endmodule

// File: tb/simt_reconv_stack_bench.sv
module simt_reconv_stack_bench;

    typedef struct packed {
        logic        st;
        logic        br;
        logic        ng;
        logic [7:0]  pr;
        logic [15:0] tg;
        logic [15:0] fl;
        logic [15:0] rc;
        logic [15:0] epc;
        logic [7:0]  em;
    } vec_t;

    function automatic vec_t mk(logic st, logic br, logic ng, logic [7:0] pr,
                                logic [15:0] tg, logic [15:0] fl, logic [15:0] rc,
                                logic [15:0] epc, logic [7:0] em);
        vec_t r;
        r.st = st; r.br = br; r.ng = ng; r.pr = pr;
        r.tg = tg; r.fl = fl; r.rc = rc; r.epc = epc; r.em = em;
        return r;
    endfunction

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 8'hFF), // R3
        mk(1'b1, 1'b1, 1'b0, 8'hFF, 16'h0010, 16'h0002, 16'h0020, 16'h0010, 8'hFF), // R4 all taken
        mk(1'b1, 1'b1, 1'b1, 8'h00, 16'h0030, 16'h0011, 16'h0040, 16'h0030, 8'hFF), // R5 negated
        mk(1'b1, 1'b1, 1'b0, 8'h00, 16'h0040, 16'h0031, 16'h0050, 16'h0031, 8'hFF), // R4 none taken
        mk(1'b1, 1'b1, 1'b0, 8'h0F, 16'h0050, 16'h0032, 16'h0060, 16'h0050, 8'h0F), // R6
        mk(1'b1, 1'b1, 1'b0, 8'h33, 16'h0070, 16'h0051, 16'h0058, 16'h0070, 8'h03), // R9 nested
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0058, 16'h0000, 16'h0051, 8'h0C), // R7 inner
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0058, 16'h0000, 16'h0058, 8'h0F), // R8 inner
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0060, 16'h0000, 16'h0032, 8'hF0), // R7 outer
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0060, 16'h0000, 16'h0060, 8'hFF), // R8 outer
        mk(1'b1, 1'b1, 1'b0, 8'h80, 16'h0080, 16'h0061, 16'h0080, 16'h0061, 8'h7F), // R11
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0080, 16'h0000, 16'h0080, 8'hFF), // R11 rejoin
        mk(1'b1, 1'b1, 1'b0, 8'h01, 16'h0090, 16'h0084, 16'h0084, 16'h0090, 8'h01), // R10 split
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0084, 16'h0000, 16'h0084, 8'hFF), // R10
        mk(1'b1, 1'b1, 1'b0, 8'h0F, 16'h00A0, 16'h0085, 16'h00C0, 16'h00A0, 8'h0F), // R12 outer
        mk(1'b1, 1'b1, 1'b0, 8'h03, 16'h00B0, 16'h00A1, 16'h00C0, 16'h00B0, 8'h03), // R12 inner
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h00C0, 16'h0000, 16'h00A1, 8'h0C), // R7
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h00C0, 16'h0000, 16'h0085, 8'hF0), // R12 double pop
        mk(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h00C0, 16'h0000, 16'h00C0, 8'hFF), // R8
        mk(1'b0, 1'b1, 1'b0, 8'h0F, 16'h0111, 16'h0222, 16'h0333, 16'h00C0, 8'hFF)  // R2 no step
    };

    localparam string VTAG [NV] = '{
        "R3", "R4", "R5", "R4", "R6", "R9", "R7", "R8", "R7", "R8",
        "R11", "R11", "R10", "R10", "R12", "R12", "R7", "R12", "R8", "R2"
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid = 1'b0;
    logic        br_valid = 1'b0;
    logic [7:0]  br_pred = '0;
    logic        br_negate = 1'b0;
    logic [15:0] target_pc = '0;
    logic [15:0] fall_pc = '0;
    logic [15:0] reconv_pc = '0;
    logic [15:0] pc_out;
    logic [7:0]  mask_out;
    logic        overflow;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    simt_reconv_stack u_simt_reconv_stack (
        .clk        (clk),
        .rst        (rst),
        .step_valid (step_valid),
        .br_valid   (br_valid),
        .br_pred    (br_pred),
        .br_negate  (br_negate),
        .target_pc  (target_pc),
        .fall_pc    (fall_pc),
        .reconv_pc  (reconv_pc),
        .pc_out     (pc_out),
        .mask_out   (mask_out),
        .overflow   (overflow)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge
    task automatic apply(logic st, logic br, logic ng, logic [7:0] pr,
                         logic [15:0] tg, logic [15:0] fl, logic [15:0] rc);
        step_valid = st; br_valid = br; br_negate = ng; br_pred = pr;
        target_pc = tg; fall_pc = fl; reconv_pc = rc;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic split(logic [7:0] pr, logic [15:0] tg, logic [15:0] fl, logic [15:0] rc,
                         logic [15:0] epc, logic [7:0] em);
        apply(1'b1, 1'b1, 1'b0, pr, tg, fl, rc);
        chk("R14", "pc", 32'(pc_out), 32'(epc));
        chk("R14", "mask", 32'(mask_out), 32'(em));
        chk("R14", "overflow", 32'(overflow), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "pc", 32'(pc_out), 32'h0);
        chk("R1", "mask", 32'(mask_out), 32'hFF);
        chk("R1", "overflow", 32'(overflow), 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].st, VEC[i].br, VEC[i].ng, VEC[i].pr, VEC[i].tg, VEC[i].fl, VEC[i].rc);
            chk(VTAG[i], "pc", 32'(pc_out), 32'(VEC[i].epc));
            chk(VTAG[i], "mask", 32'(mask_out), 32'(VEC[i].em));
        end

        // R14: four nested splits fill the default 8-entry stack
        split(8'h7F, 16'h0100, 16'h00C1, 16'h0200, 16'h0100, 8'h7F);
        split(8'h3F, 16'h0110, 16'h0101, 16'h01F0, 16'h0110, 8'h3F);
        split(8'h1F, 16'h0120, 16'h0111, 16'h01E0, 16'h0120, 8'h1F);
        split(8'h0F, 16'h0130, 16'h0121, 16'h01D0, 16'h0130, 8'h0F);

        // R13: fifth split does not fit
        apply(1'b1, 1'b1, 1'b0, 8'h07, 16'h0140, 16'h0131, 16'h01C0);
        chk("R13", "overflow", 32'(overflow), 32'd1);
        chk("R13", "pc", 32'(pc_out), 32'h0130);
        chk("R13", "mask", 32'(mask_out), 32'h0F);

        // R13: the flag stays set over an ordinary step
        apply(1'b1, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0131, 16'h0000);
        chk("R13", "sticky overflow", 32'(overflow), 32'd1);
        chk("R3", "pc", 32'(pc_out), 32'h0131);

        // R1: reset from a deep state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "pc after reset", 32'(pc_out), 32'h0);
        chk("R1", "mask after reset", 32'(mask_out), 32'hFF);
        chk("R1", "overflow after reset", 32'(overflow), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule